// File: doc/BRIEF.md
# Byte-Addressed Word Memory with Runtime Endianness

This block is a synchronous data store that software sees as a flat array of bytes, while every transfer moves one aligned 32-bit word. A run-time select chooses whether the most significant byte of a word sits at the lowest byte address (big-endian) or the least significant byte does (little-endian). The same stored bytes can be read back under either ordering, so the select changes only how lanes map onto the word, not what is stored.

Storage is split into four byte banks, one per byte offset within a word, with a shared word index. A word request whose address is not a multiple of four is refused: nothing is written, the read register keeps its value, and an error flag rises for one cycle. A combinational per-byte debug port reads any single stored byte, so the byte order in storage can be inspected directly. The depth is given in words and must be a power of two; byte addresses above the storage wrap modulo its size.

Top module: `bytemem_top`

## Requirements
- R1: While reset is active, and after its release until the first access, `rd_word` is 0 and `misalign` is 0.
- R2: With `big_endian` = 1, a write of word D at aligned byte address A stores D[31:24] at A, D[23:16] at A+1, D[15:8] at A+2 and D[7:0] at A+3, as seen on the debug port.
- R3: With `big_endian` = 0, a write of D at aligned A stores D[7:0] at A, D[15:8] at A+1, D[23:16] at A+2 and D[31:24] at A+3.
- R4: An aligned read with `rd_en` = 1 updates `rd_word` at the next clock edge with the four bytes at A..A+3 assembled per the current `big_endian`; with `rd_en` = 0, `rd_word` holds its value.
- R5: A write whose address bits [1:0] are not 00 changes no stored byte and sets `misalign` to 1 in the following cycle.
- R6: A read whose address bits [1:0] are not 00 leaves `rd_word` unchanged and sets `misalign` to 1 in the following cycle.
- R7: Consecutive words occupy byte addresses 0, 4, 8, ...; the word index is taken modulo DEPTH_WORDS, so byte address A + 4*DEPTH_WORDS reaches the same bytes as A.
- R8: A read and a write to the same aligned address in one cycle return the contents held before that write.
- R9: A word written under one ordering and read under the other comes back with its four bytes in reversed order.
- R10: `misalign` is 0 in the cycle after an idle cycle or an aligned access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| big_endian | input | 1 | 1 selects big-endian lane order, 0 little-endian |
| byte_addr | input | ADDR_W | Byte address of the word access |
| wr_word | input | 32 | Word to store |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rd_word | output | 32 | Registered read word |
| misalign | output | 1 | Registered flag for a refused unaligned request |
| dbg_addr | input | ADDR_W | Byte address for the debug view |
| dbg_byte | output | 8 | Stored byte at `dbg_addr`, combinational |

## Verification
The bench fills every word with an arithmetic pattern, alternating the ordering word by word, then inspects every stored byte through the debug port and reads each word back under both orderings; a design with a swapped lane map would show reversed bytes at the debug port, and one that mapped both modes identically would fail the cross-mode read. Unaligned writes at each of the three bad offsets are followed by debug checks of the neighbouring words, catching a design that masks the low bits and writes anyway. A same-cycle read and write targets one word to expose write-first behaviour, and an address one storage size above a word checks that the index wraps instead of being truncated wrongly or dropped.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;
   localparam int unsigned LANES  = 4;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = LANES * BYTE_W;
   typedef logic [BYTE_W-1:0]            byte_t;
   typedef logic [LANES-1:0][BYTE_W-1:0] lanes_t;
endpackage

// File: rtl/endian_lanes.sv
module endian_lanes
   import bytemem_pkg::*;
(
   input  logic                big_endian,
   input  logic [WORD_W-1:0]   wr_word,
   output lanes_t              wr_lanes,
   input  lanes_t              rd_lanes,
   output logic [WORD_W-1:0]   rd_word
);
   // lane k holds the byte stored at word offset k
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int unsigned BE_POS = LANES - 1 - k;
      localparam int unsigned LE_POS = k;
      assign wr_lanes[k] = big_endian ? wr_word[BE_POS*BYTE_W +: BYTE_W]
                                      : wr_word[LE_POS*BYTE_W +: BYTE_W];
      assign rd_word[k*BYTE_W +: BYTE_W] = big_endian ? rd_lanes[LANES-1-k]
                                                      : rd_lanes[k];
   end
endmodule

// File: rtl/access_ctl.sv
module access_ctl (
   input  logic [1:0] low_bits,
   input  logic       wr_en,
   input  logic       rd_en,
   output logic       wr_ok,
   output logic       rd_ok,
   output logic       bad
);
   logic aligned;
   assign aligned = (low_bits == 2'b00);
   assign wr_ok   = wr_en & aligned;
   assign rd_ok   = rd_en & aligned;
   assign bad     = (wr_en | rd_en) & ~aligned;
endmodule

// File: rtl/byte_bank.sv
module byte_bank
   import bytemem_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned IDX_W = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  byte_t            wbyte,
   output byte_t            rbyte,
   input  logic [IDX_W-1:0] dbg_idx,
   output byte_t            dbg_rbyte
);
   byte_t cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[idx] <= wbyte;
   end

   assign rbyte     = cells[idx];
   assign dbg_rbyte = cells[dbg_idx];
endmodule

// File: rtl/bytemem_top.sv
module bytemem_top
   import bytemem_pkg::*;
#(
   parameter int unsigned DEPTH_WORDS = 64,
   parameter int unsigned ADDR_W      = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic [ADDR_W-1:0] byte_addr,
   input  logic [31:0]       wr_word,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [31:0]       rd_word,
   output logic              misalign,
   input  logic [ADDR_W-1:0] dbg_addr,
   output logic [7:0]        dbg_byte
);
   localparam int unsigned IDX_W = $clog2(DEPTH_WORDS);
   localparam int unsigned OFS_W = $clog2(LANES);

   initial begin
      assert (DEPTH_WORDS >= 2 && (DEPTH_WORDS & (DEPTH_WORDS - 1)) == 0)
         else $error("DEPTH_WORDS must be a power of two of at least 2");
      assert (ADDR_W > IDX_W + OFS_W)
         else $error("ADDR_W must exceed the word index plus offset bits");
   end

   logic [IDX_W-1:0] widx, didx;
   logic [OFS_W-1:0] dofs;
   logic             wr_ok, rd_ok, bad;
   lanes_t           wr_lanes, rd_lanes, dbg_lanes;
   logic [31:0]      asm_word;
   logic             unused_hi;

   assign widx      = byte_addr[IDX_W+OFS_W-1:OFS_W];
   assign didx      = dbg_addr[IDX_W+OFS_W-1:OFS_W];
   assign dofs      = dbg_addr[OFS_W-1:0];
   assign unused_hi = ^{byte_addr[ADDR_W-1:IDX_W+OFS_W], dbg_addr[ADDR_W-1:IDX_W+OFS_W]};

   access_ctl u_ctl (
      .low_bits (byte_addr[OFS_W-1:0]),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .wr_ok    (wr_ok),
      .rd_ok    (rd_ok),
      .bad      (bad)
   );

   endian_lanes u_lanes (
      .big_endian (big_endian),
      .wr_word    (wr_word),
      .wr_lanes   (wr_lanes),
      .rd_lanes   (rd_lanes),
      .rd_word    (asm_word)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_bank
      byte_bank #(.DEPTH(DEPTH_WORDS)) u_bank (
         .clk       (clk),
         .we        (wr_ok),
         .idx       (widx),
         .wbyte     (wr_lanes[k]),
         .rbyte     (rd_lanes[k]),
         .dbg_idx   (didx),
         .dbg_rbyte (dbg_lanes[k])
      );
   end

   assign dbg_byte = dbg_lanes[dofs];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_word  <= '0;
         misalign <= 1'b0;
      end else begin
         misalign <= bad;
         if (rd_ok) rd_word <= asm_word;
      end
   end

   // R5 / R6: an unaligned request raises the flag one cycle later
   p_flag_unaligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && byte_addr[1:0] != 2'b00) |=> misalign);

   // R10: flag low after idle or aligned access
   p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en || rd_en) || byte_addr[1:0] == 2'b00) |=> !misalign);

   // R6 / R4: read register moves only on an aligned read
   p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || byte_addr[1:0] != 2'b00) |=> $stable(rd_word));

   // R5: the banks are never written from an unaligned address
   p_bank_write_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |-> (byte_addr[1:0] == 2'b00 && wr_en));

   // R4: an aligned read is always accepted by the read path
   p_read_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && byte_addr[1:0] == 2'b00) |-> rd_ok);
endmodule

// File: tb/bytemem_top_test.sv
`timescale 1ns/1ps
module bytemem_top_test;
   localparam int DEPTH  = 64;
   localparam int ADDR_W = 10;
   localparam int NBYTES = DEPTH * 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              big_endian = 1'b0;
   logic [ADDR_W-1:0] byte_addr = '0;
   logic [31:0]       wr_word = '0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [31:0]       rd_word;
   logic              misalign;
   logic [ADDR_W-1:0] dbg_addr = '0;
   logic [7:0]        dbg_byte;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [NBYTES];

   bytemem_top #(.DEPTH_WORDS(DEPTH), .ADDR_W(ADDR_W)) uut (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .byte_addr(byte_addr),
      .wr_word(wr_word), .wr_en(wr_en), .rd_en(rd_en), .rd_word(rd_word),
      .misalign(misalign), .dbg_addr(dbg_addr), .dbg_byte(dbg_byte)
   );

   always #4 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int w);
      logic [7:0] b = 8'(w);
      return {b ^ 8'hA5, b + 8'h11, ~b, 8'(b * 3)};
   endfunction

   // byte at offset k of a word under the given ordering
   function automatic logic [7:0] lane_of(input logic [31:0] d, input logic be, input int k);
      return be ? 8'(d >> (8 * (3 - k))) : 8'(d >> (8 * k));
   endfunction

   function automatic logic [31:0] model_word(input int a, input logic be);
      logic [31:0] r = '0;
      for (int k = 0; k < 4; k++)
         if (be) r[8*(3-k) +: 8] = model[(a + k) % NBYTES];
         else    r[8*k +: 8]     = model[(a + k) % NBYTES];
      return r;
   endfunction

   task automatic do_write(input int a, input logic [31:0] d, input logic be);
      @(negedge clk);
      byte_addr = ADDR_W'(a); wr_word = d; big_endian = be; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      if (a % 4 == 0)
         for (int k = 0; k < 4; k++) model[(a + k) % NBYTES] = lane_of(d, be, k);
   endtask

   task automatic do_read(input int a, input logic be);
      @(negedge clk);
      byte_addr = ADDR_W'(a); big_endian = be; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic check_word_bytes(input string req, input int a);
      for (int k = 0; k < 4; k++) begin
         dbg_addr = ADDR_W'(a + k);
         #1;
         check(req, {24'h0, dbg_byte}, {24'h0, model[(a + k) % NBYTES]});
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      check("R1 rd_word in reset", rd_word, 32'h0);
      check("R1 misalign in reset", {31'h0, misalign}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_word after reset", rd_word, 32'h0);
      check("R1 misalign after reset", {31'h0, misalign}, 32'h0);

      // R7 fill all consecutive words, ordering alternates per word
      for (int w = 0; w < DEPTH; w++) begin
         do_write(4 * w, pat(w), w[0]);
         check("R10 no flag after aligned write", {31'h0, misalign}, 32'h0);
      end
      // R2 (odd words, big) and R3 (even words, little) byte placement
      for (int w = 0; w < DEPTH; w++)
         check_word_bytes(w[0] ? "R2 big-endian byte" : "R3 little-endian byte", 4 * w);

      // R4 same-mode read; R9 cross-mode read gives reversed bytes
      for (int w = 0; w < DEPTH; w++) begin
         do_read(4 * w, w[0]);
         check("R4 read same ordering", rd_word, pat(w));
         do_read(4 * w, ~w[0]);
         check("R9 read other ordering", rd_word, {<<8{pat(w)}});
      end

      // R4 hold with rd_en low
      held = rd_word;
      repeat (3) @(negedge clk);
      check("R4 hold while idle", rd_word, held);

      // R5 unaligned writes at each bad offset
      for (int o = 1; o < 4; o++) begin
         do_write(4 * 5 + o, 32'hDEAD_BEEF, 1'b1);
         check("R5 flag on unaligned write", {31'h0, misalign}, 32'h1);
         check_word_bytes("R5 word unchanged", 4 * 5);
         check_word_bytes("R5 next word unchanged", 4 * 6);
      end

      // R6 unaligned read keeps rd_word
      do_read(4 * 3, 1'b1);
      held = rd_word;
      check("R6 setup read", held, model_word(12, 1'b1));
      for (int o = 1; o < 4; o++) begin
         do_read(4 * 8 + o, 1'b1);
         check("R6 flag on unaligned read", {31'h0, misalign}, 32'h1);
         check("R6 rd_word unchanged", rd_word, held);
      end
      @(negedge clk);
      check("R10 flag clears after idle", {31'h0, misalign}, 32'h0);

      // R7 wrap: one storage size above word 7
      do_write(NBYTES + 4 * 7, 32'hABCD_EF12, 1'b1);
      check_word_bytes("R7 wrapped write bytes", 4 * 7);
      dbg_addr = ADDR_W'(28); #1;
      check("R7 wrapped big byte at A", {24'h0, dbg_byte}, 32'hAB);
      do_read(4 * 7, 1'b1);
      check("R7 read after wrapped write", rd_word, 32'hABCD_EF12);
      do_read(4 * 7, 1'b0);
      check("R9 reversed after wrap", rd_word, 32'h12EF_CDAB);

      // R3 explicit little-endian example
      do_write(4 * 2, 32'hABCD_EF12, 1'b0);
      dbg_addr = ADDR_W'(8); #1;
      check("R3 little byte at A", {24'h0, dbg_byte}, 32'h12);
      dbg_addr = ADDR_W'(11); #1;
      check("R3 little byte at A+3", {24'h0, dbg_byte}, 32'hAB);

      // R8 simultaneous read and write return old contents
      held = model_word(36, 1'b1);
      @(negedge clk);
      byte_addr = ADDR_W'(36); big_endian = 1'b1; wr_word = 32'h0102_0304;
      wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      for (int k = 0; k < 4; k++) model[36 + k] = lane_of(32'h0102_0304, 1'b1, k);
      check("R8 read returns old word", rd_word, held);
      do_read(36, 1'b1);
      check("R8 later read sees new word", rd_word, 32'h0102_0304);

      report();
   end
endmodule